// File: doc/BRIEF.md
# Aging-Priority Read Request Arbiter

This block picks one of several host read ports each cycle and passes its request on to a single memory controller queue. Every port has a down-counting aging counter. The counter is loaded from a static per-port value and ticks toward zero while the port waits. The counter's most significant bits form the port's priority level, so a port that waits long enough rises in rank until it wins. Ports that share the best level are served in rotation.

Two overlays sit on top of the aging order. An urgent sideband, when enabled for a port, lifts that port above every port that is not urgent. When the global critical enable is also set, the block raises a critical flag toward the controller. A same-page option lets a port that has just won keep the grant for a bounded number of back-to-back commands that target the bank and row it last used. This saves the controller a page change.

Top module: `rdAgeArbiter`

## Requirements
- R1: On reset the grant and the critical flag are zero, and every aging counter holds its port's masked load value.
- R2: The grant is registered. It appears one clock after the requests it answers, holds at most one set bit (bit i means port i), only names a port that was valid, and is non-zero whenever at least one port was valid.
- R3: A counter's load value is the 10-bit configured value with its two least significant bits forced to 0. A counter reloads to this value on every grant to its port.
- R4: With aging enabled, a valid port that is not granted decrements its counter by 1 per cycle and stops at 0 without wrapping. With aging disabled, the counter keeps its loaded value.
- R5: A port's level is counter bits [9:5]. Among valid, non-urgent candidates the smallest level wins, and level 0 (timeout) ranks highest.
- R6: A valid port whose urgent input is high and whose urgent enable is set outranks every non-urgent port. An urgent input on a port with its enable clear has no effect.
- R7: The critical flag is registered. It is 1 in the cycle after any port has both its urgent input and urgent enable high while the global critical enable is set, whether or not that port is valid. Otherwise it is 0.
- R8: Ties in the winning set go to the first candidate at or after a rotating pointer. After each grant the pointer moves to the port just after the granted one, and it starts at port 0 after reset.
- R9: With page match enabled for the last granted port, that port is granted again when it was granted in the previous cycle, is still valid, and presents the same bank and row. At most the 4-bit limit of such extra grants happen in a row, and a limit of 0 disables this continuation.
- R10: An urgent request from a port other than the sticky one ends the page-match continuation in the same cycle.
- R11: A changed bank or row, or page match disabled for the last granted port, returns the choice to normal arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | NUM_PORTS | Read request valid per port |
| reqBank | input | NUM_PORTS*BANK_W | Bank of each port's request, port i at [i*BANK_W +: BANK_W] |
| reqRow | input | NUM_PORTS*ROW_W | Row of each port's request, port i at [i*ROW_W +: ROW_W] |
| reqUrgent | input | NUM_PORTS | Urgent sideband per port |
| cfgLoad | input | NUM_PORTS*CNT_W | Aging counter load value per port |
| cfgAgeEn | input | NUM_PORTS | Aging enable per port |
| cfgUrgEn | input | NUM_PORTS | Urgent enable per port |
| cfgPageEn | input | NUM_PORTS | Page-match enable per port |
| cfgPageLimit | input | LIMIT_W | Maximum consecutive extra same-page grants |
| cfgCritEn | input | 1 | Global enable for the critical flag |
| grant | output | NUM_PORTS | Registered one-hot grant |
| critical | output | 1 | Registered critical flag |

## Verification
The bench sets up low-bit load values so that a level boundary is crossed after one decrement when the mask is applied and after four when it is not. A design that skips the mask keeps granting the same port where the rotation should hand over. It parks a small counter behind an urgent port long enough to pass zero. A counter that wraps drops to level 31 and loses to a level-1 port it should beat, and a counter that ages with aging disabled ties and takes the grant away. Page-match runs are driven to the exact limit, cut short by a row change and broken by a foreign urgent request. An off-by-one limit, a missing tag compare or a sticky grant that ignores urgency each shows up as a wrong grant on a named cycle. Urgent inputs are also driven with the enable clear and on a port that is not valid, which separates the arbitration effect from the critical flag.

// File: rtl/rdArbPkg.sv
package rdArbPkg;
  // Widest port index carried on the control-to-datapath strobe (up to 16 ports).
  localparam int IDX_MAX_W = 4;

  typedef struct packed {
    logic                 fire;    // a grant is issued at the coming edge
    logic [IDX_MAX_W-1:0] winIdx;  // port receiving it
  } arbStrobe_t;
endpackage

// File: rtl/rdArbDatapath.sv
module rdArbDatapath
  import rdArbPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 10,
  parameter int LVL_W     = 5,
  parameter int ZERO_LSBS = 2,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  arbStrobe_t                          strobe,
  input  logic [NUM_PORTS-1:0]                reqValid,
  input  logic [NUM_PORTS*BANK_W-1:0]         reqBank,
  input  logic [NUM_PORTS*ROW_W-1:0]          reqRow,
  input  logic [NUM_PORTS*CNT_W-1:0]          cfgLoad,
  input  logic [NUM_PORTS-1:0]                cfgAgeEn,
  output logic [NUM_PORTS-1:0][LVL_W-1:0]     level,
  output logic [NUM_PORTS-1:0]                pageHit
);
  localparam logic [CNT_W-1:0] LOAD_MASK = {{(CNT_W-ZERO_LSBS){1'b1}}, {ZERO_LSBS{1'b0}}};

  logic [BANK_W-1:0] tagBank, winBank;
  logic [ROW_W-1:0]  tagRow, winRow;

  // Bank and row of the command being granted now.
  always_comb begin
    winBank = '0;
    winRow  = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (strobe.winIdx == IDX_MAX_W'(i)) begin
        winBank = reqBank[i*BANK_W +: BANK_W];
        winRow  = reqRow[i*ROW_W +: ROW_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagBank <= '0;
      tagRow  <= '0;
    end else if (strobe.fire) begin
      tagBank <= winBank;
      tagRow  <= winRow;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_age
    logic [CNT_W-1:0] ageCnt;
    logic [CNT_W-1:0] loadVal;
    logic             isWinner;

    assign loadVal  = cfgLoad[p*CNT_W +: CNT_W] & LOAD_MASK;
    assign isWinner = strobe.fire && (strobe.winIdx == IDX_MAX_W'(p));

    always_ff @(posedge clk) begin
      if (!rstN || isWinner) begin
        ageCnt <= loadVal;
      end else if (reqValid[p] && cfgAgeEn[p] && (ageCnt != '0)) begin
        ageCnt <= ageCnt - 1'b1;
      end
    end

    assign level[p]   = ageCnt[CNT_W-1 -: LVL_W];
    assign pageHit[p] = (reqBank[p*BANK_W +: BANK_W] == tagBank) &&
                        (reqRow[p*ROW_W +: ROW_W] == tagRow);
  end
endmodule

// File: rtl/rdArbPick.sv
module rdArbPick #(
  parameter int NUM_PORTS = 4,
  parameter int LVL_W     = 5,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0]            reqValid,
  input  logic [NUM_PORTS-1:0]            urgAct,
  input  logic [NUM_PORTS-1:0][LVL_W-1:0] level,
  input  logic [IDX_W-1:0]                rrPtr,
  output logic [IDX_W-1:0]                pickIdx
);
  logic [LVL_W-1:0]     minLvl;
  logic [NUM_PORTS-1:0] cand;
  logic                 found;
  int                   idx;

  always_comb begin
    minLvl = '1;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (reqValid[i] && (level[i] < minLvl)) minLvl = level[i];
    end
    // Urgent ports form the candidate set whenever any exists.
    if (|urgAct) begin
      cand = urgAct;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) cand[i] = reqValid[i] && (level[i] == minLvl);
    end
    found   = 1'b0;
    pickIdx = '0;
    idx     = 0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      idx = int'(rrPtr) + k;
      if (idx >= NUM_PORTS) idx = idx - NUM_PORTS;
      if (!found && cand[idx]) begin
        found   = 1'b1;
        pickIdx = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/rdArbControl.sv
module rdArbControl
  import rdArbPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LVL_W     = 5,
  parameter int LIMIT_W   = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_PORTS-1:0]            reqValid,
  input  logic [NUM_PORTS-1:0]            reqUrgent,
  input  logic [NUM_PORTS-1:0][LVL_W-1:0] level,
  input  logic [NUM_PORTS-1:0]            pageHit,
  input  logic [NUM_PORTS-1:0]            cfgUrgEn,
  input  logic [NUM_PORTS-1:0]            cfgPageEn,
  input  logic [LIMIT_W-1:0]              cfgPageLimit,
  input  logic                            cfgCritEn,
  output arbStrobe_t                      strobe,
  output logic [NUM_PORTS-1:0]            grant,
  output logic                            critical
);
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NUM_PORTS-1:0] urgAct;
  logic [IDX_W-1:0]     pickIdx, winIdx, rrPtr, lastIdx, rrNext;
  logic                 lastFire, anyValid, stickyOk, foreignUrgent;
  logic [LIMIT_W-1:0]   holdCnt;

  assign urgAct   = reqValid & reqUrgent & cfgUrgEn;
  assign anyValid = |reqValid;

  rdArbPick #(.NUM_PORTS(NUM_PORTS), .LVL_W(LVL_W)) i_pick (
    .reqValid (reqValid),
    .urgAct   (urgAct),
    .level    (level),
    .rrPtr    (rrPtr),
    .pickIdx  (pickIdx)
  );

  assign foreignUrgent = (|urgAct) && !urgAct[lastIdx];
  assign stickyOk = lastFire && cfgPageEn[lastIdx] && reqValid[lastIdx] &&
                    pageHit[lastIdx] && (holdCnt < cfgPageLimit) && !foreignUrgent;
  assign winIdx   = stickyOk ? lastIdx : pickIdx;
  assign rrNext   = (winIdx == IDX_W'(NUM_PORTS-1)) ? '0 : winIdx + 1'b1;

  assign strobe.fire   = anyValid;
  assign strobe.winIdx = IDX_MAX_W'(winIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grant    <= '0;
      critical <= 1'b0;
      lastFire <= 1'b0;
      lastIdx  <= '0;
      holdCnt  <= '0;
      rrPtr    <= '0;
    end else begin
      critical <= cfgCritEn && (|(reqUrgent & cfgUrgEn));
      lastFire <= anyValid;
      if (anyValid) begin
        grant   <= NUM_PORTS'(1) << winIdx;
        lastIdx <= winIdx;
        rrPtr   <= rrNext;
        holdCnt <= stickyOk ? holdCnt + 1'b1 : '0;
      end else begin
        grant   <= '0;
        holdCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/rdAgeArbiter.sv
module rdAgeArbiter
  import rdArbPkg::*;
#(
  parameter int NUM_PORTS = 4,   // at most 2**IDX_MAX_W
  parameter int CNT_W     = 10,
  parameter int LVL_W     = 5,
  parameter int ZERO_LSBS = 2,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 16,
  parameter int LIMIT_W   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [NUM_PORTS*BANK_W-1:0] reqBank,
  input  logic [NUM_PORTS*ROW_W-1:0]  reqRow,
  input  logic [NUM_PORTS-1:0]        reqUrgent,
  input  logic [NUM_PORTS*CNT_W-1:0]  cfgLoad,
  input  logic [NUM_PORTS-1:0]        cfgAgeEn,
  input  logic [NUM_PORTS-1:0]        cfgUrgEn,
  input  logic [NUM_PORTS-1:0]        cfgPageEn,
  input  logic [LIMIT_W-1:0]          cfgPageLimit,
  input  logic                        cfgCritEn,
  output logic [NUM_PORTS-1:0]        grant,
  output logic                        critical
);
  arbStrobe_t                      strobe;
  logic [NUM_PORTS-1:0][LVL_W-1:0] level;
  logic [NUM_PORTS-1:0]            pageHit;

  rdArbDatapath #(
    .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .LVL_W(LVL_W),
    .ZERO_LSBS(ZERO_LSBS), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqValid (reqValid),
    .reqBank  (reqBank),
    .reqRow   (reqRow),
    .cfgLoad  (cfgLoad),
    .cfgAgeEn (cfgAgeEn),
    .level    (level),
    .pageHit  (pageHit)
  );

  rdArbControl #(
    .NUM_PORTS(NUM_PORTS), .LVL_W(LVL_W), .LIMIT_W(LIMIT_W)
  ) i_control (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqUrgent    (reqUrgent),
    .level        (level),
    .pageHit      (pageHit),
    .cfgUrgEn     (cfgUrgEn),
    .cfgPageEn    (cfgPageEn),
    .cfgPageLimit (cfgPageLimit),
    .cfgCritEn    (cfgCritEn),
    .strobe       (strobe),
    .grant        (grant),
    .critical     (critical)
  );
endmodule

// File: rtl/rdAgeArbiterChecker.sv
module rdAgeArbiterChecker #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] reqValid,
  input logic [NUM_PORTS-1:0] reqUrgent,
  input logic [NUM_PORTS-1:0] cfgUrgEn,
  input logic                 cfgCritEn,
  input logic [NUM_PORTS-1:0] grant,
  input logic                 critical
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R2

  AST_GRANT_TO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0) |-> ((grant & $past(reqValid)) != '0)); // R2

  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |=> (grant != '0)); // R2

  AST_URGENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|(reqValid & reqUrgent & cfgUrgEn)) |=>
      ((grant & $past(reqValid & reqUrgent & cfgUrgEn)) != '0)); // R6

  AST_CRIT_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCritEn && (|(reqUrgent & cfgUrgEn))) |=> critical); // R7

  AST_CRIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgCritEn && (|(reqUrgent & cfgUrgEn))) |=> !critical); // R7
endmodule

bind rdAgeArbiter rdAgeArbiterChecker #(.NUM_PORTS(NUM_PORTS)) i_chk (.*);

// File: tb/test_rdAgeArbiter.sv
`timescale 1ns/1ps
module test_rdAgeArbiter;
  localparam int NP = 4;
  localparam int CW = 10;
  localparam int BW = 3;
  localparam int RW = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NP-1:0]    reqValid = '0, reqUrgent = '0;
  logic [NP*BW-1:0] reqBank = '0;
  logic [NP*RW-1:0] reqRow = '0;
  logic [NP*CW-1:0] cfgLoad = '0;
  logic [NP-1:0]    cfgAgeEn = '0, cfgUrgEn = '0, cfgPageEn = '0;
  logic [3:0]       cfgPageLimit = '0;
  logic             cfgCritEn = 1'b0;
  logic [NP-1:0]    grant;
  logic             critical;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;

  typedef struct {
    bit            chk;
    logic [NP-1:0] g;
    logic          c;
    string         tag;
  } expItem_t;
  expItem_t expQ[$];

  rdAgeArbiter i_rdAgeArbiter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank), .reqRow(reqRow),
    .reqUrgent(reqUrgent), .cfgLoad(cfgLoad), .cfgAgeEn(cfgAgeEn), .cfgUrgEn(cfgUrgEn),
    .cfgPageEn(cfgPageEn), .cfgPageLimit(cfgPageLimit), .cfgCritEn(cfgCritEn),
    .grant(grant), .critical(critical)
  );

  always #5 clk = ~clk;

  // Monitor: each edge answers the item pushed at the preceding falling edge.
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        if (e.chk) begin
          nTests++;
          if (grant !== e.g || critical !== e.c) begin
            nFail++;
            $display("FAIL %s: grant=%b exp=%b critical=%b exp=%b",
                     e.tag, grant, e.g, critical, e.c);
          end
        end
      end
    end
  end

  // Driver: called at a falling edge; applies inputs for the next edge and queues the result.
  task automatic cycle(input logic [NP-1:0] v, input logic [NP-1:0] u,
                       input logic [NP-1:0] expG, input logic expC, input string tag);
    expItem_t e;
    reqValid  = v;
    reqUrgent = u;
    e.chk = 1'b1; e.g = expG; e.c = expC; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic setLoad(input int p, input logic [CW-1:0] val);
    cfgLoad[p*CW +: CW] = val;
  endtask

  task automatic setTag(input int p, input logic [BW-1:0] b, input logic [RW-1:0] r);
    reqBank[p*BW +: BW] = b;
    reqRow[p*RW +: RW]  = r;
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = '0; reqUrgent = '0;
    for (int p = 0; p < NP; p++) setTag(p, 3'd1, 16'd5);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    // Setup 1: all equal levels, pure rotation.
    for (int p = 0; p < NP; p++) setLoad(p, 10'h3FF);
    doReset();
    cycle(4'b0000, 4'b0000, 4'b0000, 1'b0, "R1 reset grant and critical zero");
    cycle(4'b1111, 4'b0000, 4'b0001, 1'b0, "R8 rotation step 0");
    cycle(4'b1111, 4'b0000, 4'b0010, 1'b0, "R8 rotation step 1");
    cycle(4'b1111, 4'b0000, 4'b0100, 1'b0, "R8 rotation step 2");
    cycle(4'b1111, 4'b0000, 4'b1000, 1'b0, "R8 rotation step 3");
    cycle(4'b1111, 4'b0000, 4'b0001, 1'b0, "R8 rotation wraps");
    cycle(4'b0100, 4'b0000, 4'b0100, 1'b0, "R2 single requester");
    cycle(4'b0000, 4'b0000, 4'b0000, 1'b0, "R2 idle gives no grant");

    // Setup 2: distinct levels, urgent on port 3, critical enabled.
    setLoad(0, 10'h3FF); setLoad(1, 10'h100); setLoad(2, 10'h200); setLoad(3, 10'h3FF);
    cfgUrgEn = 4'b1000; cfgCritEn = 1'b1;
    doReset();
    cycle(4'b1111, 4'b0000, 4'b0010, 1'b0, "R5 lowest level wins (R1 load)");
    cycle(4'b1111, 4'b0000, 4'b0010, 1'b0, "R5 lowest level keeps winning");
    cycle(4'b1101, 4'b0000, 4'b0100, 1'b0, "R5 next lowest level");
    cycle(4'b1111, 4'b1000, 4'b1000, 1'b1, "R6 urgent port outranks; R7 flag");
    cycle(4'b1111, 4'b0001, 4'b0010, 1'b0, "R6 urgent without enable ignored");
    cycle(4'b0111, 4'b1000, 4'b0010, 1'b1, "R7 flag with urgent port not valid");
    cfgCritEn = 1'b0;
    cycle(4'b1111, 4'b1000, 4'b1000, 1'b0, "R7 flag off when critical enable clear");
    cfgCritEn = 1'b0;

    // Setup 3: load masking and aging across a level boundary.
    setLoad(0, 10'h043); setLoad(1, 10'h03C); setLoad(2, 10'h3FF); setLoad(3, 10'h3FF);
    cfgAgeEn = 4'b0001; cfgUrgEn = '0;
    doReset();
    cycle(4'b0011, 4'b0000, 4'b0010, 1'b0, "R3 masked load level 2 loses");
    cycle(4'b0011, 4'b0000, 4'b0001, 1'b0, "R4 one decrement reaches level 1 (R3 mask)");
    cycle(4'b0011, 4'b0000, 4'b0010, 1'b0, "R3 reload after grant");
    cycle(4'b0011, 4'b0000, 4'b0001, 1'b0, "R4 aging again after reload");

    // Setup 4: saturation at zero and aging disabled.
    setLoad(0, 10'h004); setLoad(1, 10'h020); setLoad(2, 10'h3FF); setLoad(3, 10'h3FF);
    cfgAgeEn = 4'b0001; cfgUrgEn = 4'b0100;
    doReset();
    for (int i = 0; i < 6; i++)
      cycle(4'b0111, 4'b0100, 4'b0100, 1'b0, "R6 urgent holds grant while others age");
    cycle(4'b0011, 4'b0000, 4'b0001, 1'b0, "R4 counter stays at zero, timeout wins");
    cycle(4'b0011, 4'b0000, 4'b0001, 1'b0, "R4 aging disabled counter held");

    // Setup 5: page match with limit 2.
    for (int p = 0; p < NP; p++) setLoad(p, 10'h3FF);
    cfgAgeEn = '0; cfgUrgEn = 4'b1000; cfgPageEn = 4'b0001; cfgPageLimit = 4'd2;
    doReset();
    cycle(4'b1111, 4'b0000, 4'b0001, 1'b0, "R9 first grant");
    cycle(4'b1111, 4'b0000, 4'b0001, 1'b0, "R9 extra grant 1");
    cycle(4'b1111, 4'b0000, 4'b0001, 1'b0, "R9 extra grant 2");
    cycle(4'b1111, 4'b0000, 4'b0010, 1'b0, "R9 limit reached");
    cycle(4'b1111, 4'b0000, 4'b0100, 1'b0, "R11 page disabled port rotates");
    cycle(4'b1111, 4'b0000, 4'b1000, 1'b0, "R11 rotation continues");
    cycle(4'b1111, 4'b0000, 4'b0001, 1'b0, "R9 port 0 granted again");
    setTag(0, 3'd1, 16'd6);
    cycle(4'b1111, 4'b0000, 4'b0010, 1'b0, "R11 row change ends continuation");

    // Setup 6: foreign urgent breaks continuation.
    cfgPageLimit = 4'd4;
    doReset();
    cycle(4'b1111, 4'b0000, 4'b0001, 1'b0, "R10 first grant");
    cycle(4'b1111, 4'b0000, 4'b0001, 1'b0, "R10 sticky grant");
    cycle(4'b1111, 4'b1000, 4'b1000, 1'b0, "R10 urgent breaks continuation");
    cycle(4'b0000, 4'b0000, 4'b0000, 1'b0, "R2 idle at end");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule